// File: doc/BRIEF.md
# SMBus Line State Monitor

This block observes the clock and data lines of a battery-gauge SMBus slave and turns their long-term levels into bus conditions. It does not decode bits. Each raw pin is synchronized, then filtered so that a level is accepted only after three agreeing samples. A set of saturating millisecond timers measures how long each line condition has lasted.

A clock line held low past a fixed 30 ms limit, or both lines held high for 50 ms, produces a one-cycle abort pulse. The protocol engine uses that pulse to drop any transfer in progress. Both lines held low for 2 s put the bus into the off state, which lasts until either line goes high again. A ready flag returns on the next millisecond tick after that release. If both lines stay low for 5 s, the block raises a single request to start offset auto-calibration.

All durations are counted on an external one-cycle millisecond tick that is synchronous to the clock.

Top module: `smbus_line_monitor`

## Requirements
- R1: Each pin passes through a two-flop synchronizer and a filter that accepts a new level only after 3 consecutive agreeing synchronized samples. A pulse on a pin shorter than 3 clock cycles has no effect on any timer or output.
- R2: When the filtered clock line has been low for ABORT_MS (default 30) ticks, abort_o pulses high for exactly one cycle. No abort comes from a clock-low period shorter than that.
- R3: When both filtered lines have been high for IDLE_MS (default 50) ticks, abort_o pulses high for exactly one cycle.
- R4: bus_off_o goes high once both filtered lines have been low for OFF_MS (default 2000) ticks. It is low before that point.
- R5: bus_off_o returns low as soon as either filtered line is high.
- R6: bus_ready_o goes high READY_MS (default 1) ticks after reset, or after bus_off_o clears. bus_off_o and bus_ready_o are never high together.
- R7: When both filtered lines have been low for CAL_MS (default 5000) ticks, cal_req_o pulses high once. The request re-arms only after a line goes high.
- R8: Every timer saturates instead of wrapping. A condition held far beyond its limit gives one pulse and no more.
- R9: While rst is high, abort_o, bus_off_o, bus_ready_o and cal_req_o are all low.
- R10: Breaking a condition restarts its timer from zero. Two clock-low periods of 20 ticks each, separated by a high level, give no abort.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle millisecond enable, synchronous to clk |
| smbc_pin | input | 1 | Raw SMBus clock line |
| smbd_pin | input | 1 | Raw SMBus data line |
| abort_o | output | 1 | One-cycle pulse: clock-low timeout or idle reset |
| bus_off_o | output | 1 | Level: bus is in the off state |
| bus_ready_o | output | 1 | Level: bus available for communication |
| cal_req_o | output | 1 | One-cycle pulse: start offset auto-calibration |

## Verification
A pin edge reaches the filtered level six clock edges later: two for the synchronizer, three for the filter history and one for the level register. A timer that reaches its limit on a tick raises abort_o or cal_req_o one edge after that tick. The bus_off_o and bus_ready_o flags follow their counters by one edge. The bench's reference model applies these delays to the raw pin and tick values it drives. It compares all four outputs at every falling edge, halfway between the edges where they change. The directed event counts are read only after that pipeline delay has passed.

// File: rtl/smbmon_pkg.sv
package smbmon_pkg;
  localparam int unsigned NUM_LINES = 2;
  localparam int unsigned IDX_CLK   = 0;
  localparam int unsigned IDX_DAT   = 1;

  // bits needed to hold the values 0..lim
  function automatic int unsigned span_width(input int unsigned lim);
    return $clog2(lim + 1);
  endfunction
endpackage

// File: rtl/line_conditioner.sv
module line_conditioner #(
  parameter int unsigned FILT_LEN  = 3,
  parameter bit          RST_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic level_o
);
  logic [1:0]          sync_q;
  logic [FILT_LEN-1:0] hist_q;
  logic                level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= {2{RST_LEVEL}};
      hist_q  <= {FILT_LEN{RST_LEVEL}};
      level_q <= RST_LEVEL;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
      if (&hist_q)
        level_q <= 1'b1;
      else if (~|hist_q)
        level_q <= 1'b0;
    end
  end

  assign level_o = level_q;

  // R1: after an accepted change the level stays put for at least one more edge
  p_filter_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !$stable(level_q) |=> $stable(level_q))
    else $error("filtered level toggled on consecutive edges");
endmodule

// File: rtl/span_timer.sv
module span_timer import smbmon_pkg::*; #(
  parameter int unsigned LIMIT = 30,
  parameter bit          PULSE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic active_i,
  output logic flag_o
);
  localparam int unsigned W      = span_width(LIMIT);
  localparam logic [W-1:0] LIM_W  = W'(LIMIT);
  localparam logic [W-1:0] LIM_M1 = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;
  logic         at_lim;

  assign at_lim = (cnt_q == LIM_W);

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (!active_i)
      cnt_q <= '0;
    else if (tick_i && !at_lim)
      cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (PULSE) begin : g_pulse
      logic hit_q;
      always_ff @(posedge clk) begin
        if (rst)
          hit_q <= 1'b0;
        else
          hit_q <= active_i && tick_i && (cnt_q == LIM_M1);
      end
      assign flag_o = hit_q;

      // R8: a threshold crossing yields a single-cycle event
      p_hit_single_r8: assert property (@(posedge clk) disable iff (rst)
        hit_q |=> !hit_q)
        else $error("timer event longer than one cycle");
    end else begin : g_level
      assign flag_o = at_lim;
    end
  endgenerate

  // R8: the count never passes its limit
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIM_W)
    else $error("timer count beyond limit");
endmodule

// File: rtl/smbus_line_monitor.sv
module smbus_line_monitor import smbmon_pkg::*; #(
  parameter int unsigned ABORT_MS = 30,
  parameter int unsigned IDLE_MS  = 50,
  parameter int unsigned OFF_MS   = 2000,
  parameter int unsigned CAL_MS   = 5000,
  parameter int unsigned READY_MS = 1,
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic ms_tick,
  input  logic smbc_pin,
  input  logic smbd_pin,
  output logic abort_o,
  output logic bus_off_o,
  output logic bus_ready_o,
  output logic cal_req_o
);
  logic [NUM_LINES-1:0] pins;
  logic [NUM_LINES-1:0] lvl;
  logic clk_low, both_high, both_low;
  logic low_evt, idle_evt, cal_evt, off_flag, ready_flag;
  logic abort_q, bus_off_q, bus_ready_q, cal_q;

  assign pins[IDX_CLK] = smbc_pin;
  assign pins[IDX_DAT] = smbd_pin;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    line_conditioner #(
      .FILT_LEN (FILT_LEN),
      .RST_LEVEL(1'b1)
    ) u_cond (
      .clk    (clk),
      .rst    (rst),
      .pin_i  (pins[g]),
      .level_o(lvl[g])
    );
  end

  assign clk_low   = ~lvl[IDX_CLK];
  assign both_high = &lvl;
  assign both_low  = ~|lvl;

  span_timer #(.LIMIT(ABORT_MS), .PULSE(1'b1)) u_clk_low (
    .clk(clk), .rst(rst), .tick_i(ms_tick), .active_i(clk_low), .flag_o(low_evt));

  span_timer #(.LIMIT(IDLE_MS), .PULSE(1'b1)) u_idle (
    .clk(clk), .rst(rst), .tick_i(ms_tick), .active_i(both_high), .flag_o(idle_evt));

  span_timer #(.LIMIT(OFF_MS), .PULSE(1'b0)) u_off (
    .clk(clk), .rst(rst), .tick_i(ms_tick), .active_i(both_low), .flag_o(off_flag));

  span_timer #(.LIMIT(CAL_MS), .PULSE(1'b1)) u_cal (
    .clk(clk), .rst(rst), .tick_i(ms_tick), .active_i(both_low), .flag_o(cal_evt));

  span_timer #(.LIMIT(READY_MS), .PULSE(1'b0)) u_ready (
    .clk(clk), .rst(rst), .tick_i(ms_tick), .active_i(~off_flag), .flag_o(ready_flag));

  always_ff @(posedge clk) begin
    if (rst) begin
      abort_q     <= 1'b0;
      bus_off_q   <= 1'b0;
      bus_ready_q <= 1'b0;
      cal_q       <= 1'b0;
    end else begin
      abort_q     <= low_evt | idle_evt;
      bus_off_q   <= off_flag;
      bus_ready_q <= ready_flag & ~off_flag;
      cal_q       <= cal_evt;
    end
  end

  assign abort_o     = abort_q;
  assign bus_off_o   = bus_off_q;
  assign bus_ready_o = bus_ready_q;
  assign cal_req_o   = cal_q;

  // R6: off and ready are mutually exclusive
  p_off_ready_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(bus_off_o && bus_ready_o))
    else $error("bus off and ready both high");

  // R2: abort is a single-cycle pulse
  p_abort_single_r2: assert property (@(posedge clk) disable iff (rst)
    abort_o |=> !abort_o)
    else $error("abort longer than one cycle");

  // R7: calibration request is a single-cycle pulse
  p_cal_single_r7: assert property (@(posedge clk) disable iff (rst)
    cal_req_o |=> !cal_req_o)
    else $error("calibration request longer than one cycle");

  // R4: entering bus-off follows a tick taken with both lines low
  p_off_entry_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_off_o) |-> ($past(both_low, 2) && $past(ms_tick, 2)))
    else $error("bus off entered without a low-line tick");

  // R5: leaving bus-off follows a line going high
  p_off_exit_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_off_o) |-> !$past(both_low, 2))
    else $error("bus off left while both lines low");

  // R6: ready returns only on a counted tick
  p_ready_tick_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_ready_o) |-> $past(ms_tick, 2))
    else $error("ready rose without a tick");
endmodule

// File: tb/sim_smbus_line_monitor.sv
`timescale 1ns/1ps
module sim_smbus_line_monitor;
  localparam int ABORT = 30;
  localparam int IDLE  = 50;
  localparam int OFF   = 2000;
  localparam int CAL   = 5000;
  localparam int RDY   = 1;
  localparam int TD    = 3;       // clock cycles per millisecond tick
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ms_tick = 1'b0;
  logic smbc_pin = 1'b1;
  logic smbd_pin = 1'b1;
  logic abort_o, bus_off_o, bus_ready_o, cal_req_o;

  int n_chk = 0;
  int n_fail = 0;
  int abort_cnt = 0;
  int cal_cnt = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  smbus_line_monitor u0 (
    .clk(clk), .rst(rst), .ms_tick(ms_tick),
    .smbc_pin(smbc_pin), .smbd_pin(smbd_pin),
    .abort_o(abort_o), .bus_off_o(bus_off_o),
    .bus_ready_o(bus_ready_o), .cal_req_o(cal_req_o));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // free-running millisecond tick, driven away from the active edge
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv == TD - 1) ? 0 : tdiv + 1;
    ms_tick <= (tdiv == 0);
  end

  // ---------------- behavioural reference model ----------------
  int hc[$];
  int hd[$];
  int lc, ld;
  int c_low, c_idle, c_off, c_cal, c_rdy;
  bit p_low, p_idle, p_cal;
  bit e_abort, e_off, e_rdy, e_cal;
  bit live = 1'b0;

  function automatic int filt(input int q[$], input int cur);
    // accepted level uses the 3 samples seen 3..5 edges ago
    if (q[3] == 1 && q[4] == 1 && q[5] == 1) return 1;
    if (q[3] == 0 && q[4] == 0 && q[5] == 0) return 0;
    return cur;
  endfunction

  function automatic int step(input int c, input bit act, input bit t, input int lim);
    if (!act) return 0;
    if (t && c < lim) return c + 1;
    return c;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      hc = {1, 1, 1, 1, 1, 1};
      hd = {1, 1, 1, 1, 1, 1};
      lc = 1; ld = 1;
      c_low = 0; c_idle = 0; c_off = 0; c_cal = 0; c_rdy = 0;
      p_low = 0; p_idle = 0; p_cal = 0;
      e_abort = 0; e_off = 0; e_rdy = 0; e_cal = 0;
      live = 1'b1;
    end else begin
      bit t, a_low, a_idle, a_both, a_rdy;
      t      = ms_tick;
      a_low  = (lc == 0);
      a_idle = (lc == 1 && ld == 1);
      a_both = (lc == 0 && ld == 0);
      a_rdy  = (c_off != OFF);
      e_abort = p_low | p_idle;
      e_off   = (c_off == OFF);
      e_rdy   = (c_rdy == RDY) && (c_off != OFF);
      e_cal   = p_cal;
      p_low  = a_low  && t && (c_low  == ABORT - 1);
      p_idle = a_idle && t && (c_idle == IDLE - 1);
      p_cal  = a_both && t && (c_cal  == CAL - 1);
      c_low  = step(c_low,  a_low,  t, ABORT);
      c_idle = step(c_idle, a_idle, t, IDLE);
      c_off  = step(c_off,  a_both, t, OFF);
      c_cal  = step(c_cal,  a_both, t, CAL);
      c_rdy  = step(c_rdy,  a_rdy,  t, RDY);
      hc.push_front(int'(smbc_pin)); void'(hc.pop_back());
      hd.push_front(int'(smbd_pin)); void'(hd.pop_back());
      lc = filt(hc, lc);
      ld = filt(hd, ld);
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (live && !done) begin
      chk("R2 R3 abort_o", int'(abort_o), int'(e_abort));
      chk("R4 R5 bus_off_o", int'(bus_off_o), int'(e_off));
      chk("R6 bus_ready_o", int'(bus_ready_o), int'(e_rdy));
      chk("R7 cal_req_o", int'(cal_req_o), int'(e_cal));
      if (!rst) begin
        if (abort_o) abort_cnt++;
        if (cal_req_o) cal_cnt++;
      end
    end
  end

  task automatic wait_ms(input int ms);
    repeat (ms * TD) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    int snap;
    repeat (4) @(negedge clk);
    // R9: reset state
    chk("R9 abort in reset", int'(abort_o), 0);
    chk("R9 bus_off in reset", int'(bus_off_o), 0);
    chk("R9 ready in reset", int'(bus_ready_o), 0);
    chk("R9 cal in reset", int'(cal_req_o), 0);
    rst = 1'b0;

    // R1: 2-cycle glitch on the clock line must not restart the idle timer
    repeat (60) @(negedge clk);
    smbc_pin = 1'b0;
    repeat (2) @(negedge clk);
    smbc_pin = 1'b1;
    repeat (105) @(negedge clk);
    @(posedge clk);
    chk("R1 idle abort despite glitch", abort_cnt, 1);
    chk("R6 ready after reset", int'(bus_ready_o), 1);

    // R2 / R8: clock held low for 100 ms
    wait_ms(20);
    @(negedge clk);
    snap = abort_cnt;
    smbc_pin = 1'b0;
    wait_ms(28);
    @(posedge clk);
    chk("R2 no abort before limit", abort_cnt - snap, 0);
    wait_ms(72);
    smbc_pin = 1'b1;
    repeat (10) @(negedge clk);
    @(posedge clk);
    chk("R8 single abort over long low", abort_cnt - snap, 1);

    // R3: idle abort after the line returns high
    @(negedge clk);
    snap = abort_cnt;
    wait_ms(55);
    @(posedge clk);
    chk("R3 idle abort", abort_cnt - snap, 1);

    // R10: broken clock-low periods restart the timer
    @(negedge clk);
    snap = abort_cnt;
    smbc_pin = 1'b0;
    wait_ms(20);
    smbc_pin = 1'b1;
    wait_ms(2);
    smbc_pin = 1'b0;
    wait_ms(20);
    smbc_pin = 1'b1;
    repeat (10) @(negedge clk);
    @(posedge clk);
    chk("R10 no abort after restart", abort_cnt - snap, 0);
    wait_ms(60);

    // R4 / R5 / R6: bus-off entry and release
    @(negedge clk);
    smbc_pin = 1'b0;
    smbd_pin = 1'b0;
    wait_ms(1990);
    @(posedge clk);
    chk("R4 not off early", int'(bus_off_o), 0);
    wait_ms(110);
    @(posedge clk);
    chk("R4 bus off", int'(bus_off_o), 1);
    chk("R6 not ready while off", int'(bus_ready_o), 0);
    @(negedge clk);
    smbd_pin = 1'b1;
    repeat (10) @(negedge clk);
    @(posedge clk);
    chk("R5 off cleared", int'(bus_off_o), 0);
    repeat (2 * TD + 2) @(negedge clk);
    @(posedge clk);
    chk("R6 ready after release", int'(bus_ready_o), 1);

    // R7: calibration request once per low period, re-armed by a high line
    @(negedge clk);
    smbc_pin = 1'b1;
    wait_ms(60);
    snap = cal_cnt;
    smbc_pin = 1'b0;
    smbd_pin = 1'b0;
    wait_ms(6000);
    @(posedge clk);
    chk("R7 one request", cal_cnt - snap, 1);
    @(negedge clk);
    smbc_pin = 1'b1;
    wait_ms(5);
    smbc_pin = 1'b0;
    wait_ms(5100);
    @(posedge clk);
    chk("R7 re-armed request", cal_cnt - snap, 2);
    @(negedge clk);
    smbc_pin = 1'b1;
    smbd_pin = 1'b1;
    wait_ms(5);

    finish_run();
  end

  initial begin
    wait (cyc >= WATCHDOG);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WATCHDOG);
      finish_run();
    end
  end
endmodule